// File: doc/BRIEF.md
# Page Write Collector with Upper-Half Protection

The block gathers the data bytes of one write transaction into a small page buffer and later copies them into a byte-wide memory array. A transaction is opened by a start strobe that carries the first word address. Each byte strobe stores one byte at the current position and advances only the offset within the page. The page base, which is the upper address bits, stays fixed. When the commit pulse arrives at the end of the transaction, the block becomes busy for a fixed number of clock cycles. During the final cycles of that interval it writes every received location into the array, one location per cycle.

A protect input shields the upper half of the array. When protect is high at commit and the page lies in that half, the block writes nothing. It still stays busy for the full interval, so a host polling for completion sees the same timing for every write. While busy, the block ignores all transaction inputs. The array address and data outputs are meaningful only in a cycle where the write enable is high.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are low.
- R2: A start strobe latches `start_addr_i`. The upper AW-3 bits form the page base and the low 3 bits form the starting offset. Each byte strobe stores `byte_i` at the address {base, offset} and then advances the offset by one.
- R3: With the default page of 8 bytes, the offset wraps from 7 back to 0 and the base never changes. When more than 8 bytes are sent, the later bytes overwrite the earlier bytes at the same offsets.
- R4: A commit pulse taken while idle with at least one byte collected raises `busy_o` on the next cycle. `busy_o` then stays high for exactly BUSY_CYCLES consecutive cycles (default 20).
- R5: Only the offsets that received a byte are written, each exactly once. Offset k is written in busy cycle BUSY_CYCLES-8+k+1, counting the first busy cycle as 1, so writes go in ascending offset order within the last 8 busy cycles. `mem_we_o` is never high while `busy_o` is low.
- R6: When `wp_i` is high at the commit edge and the most significant address bit of the page is 1 (addresses 0x80 to 0xFF), no array write occurs. `busy_o` still stays high for BUSY_CYCLES cycles.
- R7: When `wp_i` is high at commit and the page lies in the lower half, all received bytes are written normally.
- R8: While `busy_o` is high, start, byte and commit strobes have no effect. They store nothing, write nothing and do not extend the busy interval.
- R9: A commit pulse when no byte has been collected leaves `busy_o` low and writes nothing.
- R10: When the busy interval ends, the received-byte record is cleared. A later transaction writes only the bytes sent in that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a transaction and latches the start address |
| start_addr_i | input | AW | First word address of the transaction |
| byte_vld_i | input | 1 | Strobe for one received data byte |
| byte_i | input | DW | Received data byte |
| commit_i | input | 1 | End-of-transaction pulse that requests the array update |
| wp_i | input | 1 | Protects the upper half of the array when high |
| busy_o | output | 1 | High during the write interval |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | AW | Array write address |
| mem_wdata_o | output | DW | Array write data |

## Verification
The bench sends a page that starts in the middle and runs two bytes past its end. A design that carried the offset into the base would write into the next page. A design that did not wrap would drop the last bytes. A single-byte write checks both the write count and the exact busy cycle in which the write lands, which catches an off-by-one in the drain slot mapping. Protected-page commits must keep the full busy length while producing no write. A blocked write that skipped the busy interval, or that leaked one byte, is reported. Strobes sent during busy are followed by an idle commit that must not go busy; a design that stored those bytes would start a second write.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_BUSY = 1'b1
  } pwb_phase_e;
endpackage

// File: rtl/pwb_collect.sv
module pwb_collect #(
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned PAGE = 8,
  localparam int unsigned OW  = $clog2(PAGE),
  localparam int unsigned BW  = AW - OW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               start_i,
  input  logic [AW-1:0]      start_addr_i,
  input  logic               byte_vld_i,
  input  logic [DW-1:0]      byte_i,
  input  logic               clr_i,
  output logic [BW-1:0]      base_o,
  output logic [PAGE-1:0]    vld_o,
  output logic [PAGE*DW-1:0] data_o
);
  logic [BW-1:0]   base_q;
  logic [OW-1:0]   ofs_q;
  logic [PAGE-1:0] vld_q;
  logic [DW-1:0]   buf_q [PAGE];

  wire take_start = en_i && start_i;
  wire take_byte  = en_i && byte_vld_i && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ofs_q  <= '0;
      vld_q  <= '0;
    end else if (take_start) begin
      base_q <= start_addr_i[AW-1:OW];
      ofs_q  <= start_addr_i[OW-1:0];
      vld_q  <= '0;
    end else if (take_byte) begin
      vld_q[ofs_q] <= 1'b1;
      ofs_q        <= ofs_q + 1'b1;  // wraps inside the page
    end else if (clr_i) begin
      vld_q <= '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (take_byte) buf_q[ofs_q] <= byte_i;
  end

  for (genvar g = 0; g < PAGE; g++) begin : g_flat
    assign data_o[g*DW +: DW] = buf_q[g];
  end

  assign base_o = base_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer
  import pwb_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 20,
  parameter int unsigned PAGE        = 8,
  localparam int unsigned OW         = $clog2(PAGE),
  localparam int unsigned CW         = $clog2(BUSY_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  output logic          busy_o,
  output logic          last_o,
  output logic          drain_o,
  output logic [OW-1:0] slot_o
);
  pwb_phase_e    ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (ph_q == PH_IDLE) begin
      if (go_i) begin
        ph_q  <= PH_BUSY;
        cnt_q <= CW'(BUSY_CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      ph_q <= PH_IDLE;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o  = (ph_q == PH_BUSY);
  assign last_o  = busy_o && (cnt_q == '0);
  // array updates fill the final PAGE cycles of the interval
  assign drain_o = busy_o && (cnt_q < CW'(PAGE));
  assign slot_o  = OW'(CW'(PAGE - 1) - cnt_q);
endmodule

// File: rtl/pwb_drain.sv
module pwb_drain #(
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned PAGE = 8,
  localparam int unsigned OW  = $clog2(PAGE),
  localparam int unsigned BW  = AW - OW
) (
  input  logic               drain_i,
  input  logic [OW-1:0]      slot_i,
  input  logic               prot_i,
  input  logic [BW-1:0]      base_i,
  input  logic [PAGE-1:0]    vld_i,
  input  logic [PAGE*DW-1:0] data_i,
  output logic               we_o,
  output logic [AW-1:0]      addr_o,
  output logic [DW-1:0]      wdata_o
);
  assign we_o    = drain_i && vld_i[slot_i] && !prot_i;
  assign addr_o  = {base_i, slot_i};
  assign wdata_o = data_i[slot_i*DW +: DW];
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int unsigned AW          = 8,
  parameter int unsigned DW          = 8,
  parameter int unsigned PAGE        = 8,
  parameter int unsigned BUSY_CYCLES = 20,
  localparam int unsigned OW         = $clog2(PAGE),
  localparam int unsigned BW         = AW - OW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic          commit_i,
  input  logic          wp_i,
  output logic          busy_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);
  logic [BW-1:0]      base;
  logic [PAGE-1:0]    vld;
  logic [PAGE*DW-1:0] data;
  logic               busy, last, drain, go, any_vld, wp_q;
  logic [OW-1:0]      slot;

  assign any_vld = |vld;
  assign go      = commit_i && !busy && any_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  wp_q <= 1'b0;
    else if (go)  wp_q <= wp_i;
  end

  pwb_collect #(.AW(AW), .DW(DW), .PAGE(PAGE)) u_collect (
    .clk_i, .rst_ni,
    .en_i        (!busy),
    .start_i,
    .start_addr_i,
    .byte_vld_i,
    .byte_i,
    .clr_i       (last),
    .base_o      (base),
    .vld_o       (vld),
    .data_o      (data)
  );

  pwb_timer #(.BUSY_CYCLES(BUSY_CYCLES), .PAGE(PAGE)) u_timer (
    .clk_i, .rst_ni,
    .go_i    (go),
    .busy_o  (busy),
    .last_o  (last),
    .drain_o (drain),
    .slot_o  (slot)
  );

  pwb_drain #(.AW(AW), .DW(DW), .PAGE(PAGE)) u_drain (
    .drain_i (drain),
    .slot_i  (slot),
    .prot_i  (wp_q && base[BW-1]),
    .base_i  (base),
    .vld_i   (vld),
    .data_i  (data),
    .we_o    (mem_we_o),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/page_write_buffer_chk.sv
module page_write_buffer_chk #(
  parameter int unsigned AW          = 8,
  parameter int unsigned BUSY_CYCLES = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          commit_i,
  input logic          busy_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          wp_q_i,
  input logic          pend_i
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= '0;
  end

  AST_WE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);  // R5

  AST_COMMIT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !busy_o && pend_i) |=> busy_o);  // R4

  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && run_q == BUSY_CYCLES) |-> 1'b0);  // R4

  AST_BUSY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && run_q != 0) |-> (run_q == BUSY_CYCLES));  // R6

  AST_PROT_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !(wp_q_i && mem_addr_o[AW-1]));  // R6
endmodule

bind page_write_buffer page_write_buffer_chk #(.AW(AW), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .commit_i   (commit_i),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .wp_q_i     (wp_q),
  .pend_i     (any_vld)
);

// File: tb/tb_page_write_buffer.sv
`timescale 1ns/1ps
module tb_page_write_buffer;
  localparam int AW = 8, DW = 8, PAGE = 8, BUSY = 20;

  logic clk = 0, rst_n = 0;
  logic start = 0, bv = 0, commit = 0, wp = 0;
  logic [AW-1:0] saddr = '0;
  logic [DW-1:0] bd = '0;
  logic busy, we;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;

  page_write_buffer #(.AW(AW), .DW(DW), .PAGE(PAGE), .BUSY_CYCLES(BUSY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(saddr),
    .byte_vld_i(bv), .byte_i(bd), .commit_i(commit), .wp_i(wp),
    .busy_o(busy), .mem_we_o(we), .mem_addr_o(waddr), .mem_wdata_o(wdata));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] arr [256];
  logic [DW-1:0] exp_arr [256];
  int bidx = 0, last_len = 0, nwr = 0, first_idx = 0, we_idle = 0;
  bit done = 0;

  // array model and busy-run monitor
  always @(negedge clk) begin
    if (busy) begin
      bidx = bidx + 1;
      if (we) begin
        nwr = nwr + 1;
        if (nwr == 1) first_idx = bidx;
        arr[waddr] = wdata;
      end
    end else begin
      if (we) we_idle = we_idle + 1;
      if (bidx != 0) last_len = bidx;
      bidx = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_arr(input string req);
    int bad = 0;
    int bad_a = 0;
    for (int i = 0; i < 256; i++)
      if (arr[i] !== exp_arr[i]) begin
        if (bad == 0) bad_a = i;
        bad++;
      end
    check(bad == 0, req, bad == 0 ? 0 : int'(arr[bad_a]), bad == 0 ? 0 : int'(exp_arr[bad_a]));
  endtask

  task automatic p_start(input logic [AW-1:0] a);
    @(negedge clk); start = 1; saddr = a;
    @(negedge clk); start = 0;
  endtask
  task automatic p_byte(input logic [DW-1:0] b);
    @(negedge clk); bv = 1; bd = b;
    @(negedge clk); bv = 0;
  endtask
  task automatic p_commit;
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
  endtask
  task automatic wait_idle;
    int g = 0;
    while (busy && g < 1000) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask
  task automatic clr_stats;
    nwr = 0; first_idx = 0; last_len = 0;
  endtask

  task automatic t_reset;
    check(busy == 0, "R1 busy", busy, 0);
    check(we == 0, "R1 we", we, 0);
  endtask

  task automatic t_byte_write;
    clr_stats();
    p_start(8'h13); p_byte(8'hA5); p_commit();
    check(busy == 1, "R4 busy rise", busy, 1);
    wait_idle();
    exp_arr[8'h13] = 8'hA5;
    check(last_len == BUSY, "R4 busy length", last_len, BUSY);
    check(nwr == 1, "R5 write count", nwr, 1);
    check(first_idx == BUSY - PAGE + 3 + 1, "R5 write slot", first_idx, BUSY - PAGE + 4);
    chk_arr("R2 byte write");
  endtask

  task automatic t_wrap;
    clr_stats();
    p_start(8'h2E);
    for (int k = 0; k < 10; k++) begin
      p_byte(8'(8'h60 + k));
      exp_arr[{5'h05, 3'(6 + k)}] = 8'(8'h60 + k);
    end
    p_commit(); wait_idle();
    check(nwr == 8, "R3 wrap count", nwr, 8);
    check(first_idx == BUSY - PAGE + 1, "R5 first slot", first_idx, BUSY - PAGE + 1);
    chk_arr("R3 wrap overwrite");
  endtask

  task automatic t_protect;
    clr_stats();
    wp = 1;
    p_start(8'h90); p_byte(8'h01); p_byte(8'h02); p_byte(8'h03);
    p_commit();
    check(busy == 1, "R6 busy rise", busy, 1);
    wait_idle();
    check(nwr == 0, "R6 no write", nwr, 0);
    check(last_len == BUSY, "R6 busy length", last_len, BUSY);
    chk_arr("R6 array");
    clr_stats();
    p_start(8'h44); p_byte(8'h5A); p_byte(8'hC3);
    p_commit(); wait_idle();
    exp_arr[8'h44] = 8'h5A; exp_arr[8'h45] = 8'hC3;
    check(nwr == 2, "R7 lower half writes", nwr, 2);
    chk_arr("R7 array");
    wp = 0;
  endtask

  task automatic t_busy_ignore;
    clr_stats();
    p_start(8'h70); p_byte(8'h11); p_commit();
    p_start(8'h78); p_byte(8'hEE); p_commit();
    wait_idle();
    exp_arr[8'h70] = 8'h11;
    check(last_len == BUSY, "R8 busy not extended", last_len, BUSY);
    check(nwr == 1, "R8 write count", nwr, 1);
    chk_arr("R8 array");
    p_commit();
    check(busy == 0, "R8 no stored byte", busy, 0);
  endtask

  task automatic t_empty;
    clr_stats();
    p_start(8'h30); p_commit();
    check(busy == 0, "R9 no busy", busy, 0);
    repeat (BUSY + 2) @(negedge clk);
    check(nwr == 0, "R9 no write", nwr, 0);
  endtask

  task automatic t_clear;
    clr_stats();
    p_start(8'h50);
    for (int k = 0; k < 4; k++) begin
      p_byte(8'(8'hB0 + k));
      exp_arr[8'(8'h50 + k)] = 8'(8'hB0 + k);
    end
    p_commit(); wait_idle();
    check(nwr == 4, "R10 first txn", nwr, 4);
    clr_stats();
    p_start(8'h58); p_byte(8'hD7); p_commit(); wait_idle();
    exp_arr[8'h58] = 8'hD7;
    check(nwr == 1, "R10 second txn", nwr, 1);
    chk_arr("R10 array");
    check(we_idle == 0, "R5 no idle write", we_idle, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin arr[i] = '0; exp_arr[i] = '0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_byte_write();
    t_wrap();
    t_protect();
    t_busy_ignore();
    t_empty();
    t_clear();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule